// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-serviced watchdog for a system controller. Software programs a timeout count and clears a halt bit so that the count runs. While it runs, the counter steps down by one on every tick-enable pulse, and software keeps it alive by writing any value to a reload register. If the counter runs out once, the block only raises a first-timeout flag and refills the counter from the programmed timeout, so software gets a second window to recover.

If the counter runs out a second time in a row with no reload in between, the block sets a second-timeout flag and issues a one-cycle system reset request. A no-reboot control bit blocks that request. The bit can be set by software, and it is also forced on by a strap input. A boot-status flag records that a reset request was issued.

A parameter selects one of two variants. The wide variant has a 10-bit timeout field in a 16-bit timer register. The legacy variant has a 6-bit field in an 8-bit register. The tick prescaler and any interrupt generation lie outside the block.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the control register reads 0x0001 (halt bit 0 set, no-reboot bit 1 clear), the timer register reads the default timeout 4, the status register reads 0, and `rst_req` is low.
- R2: The register map is: address 0 control, 1 timer, 2 reload, 3 status. A write to the timer register (address 1) changes only the timeout field, bits [9:0] in wide mode and bits [5:0] in legacy mode. The remaining register bits read 0 and a write does not change them.
- R3: While the halt bit is clear, a timer write whose field is outside 2..613 (wide) or 4..39 (legacy) is ignored and the previous timeout is kept. While halt is set, any field value is accepted.
- R4: With halt clear, each `tick` pulse decrements the counter. On the T-th tick after a reload with timeout T, the first-timeout flag (status bit 0) sets and the counter refills from the timeout.
- R5: While the halt bit is set, ticks do not change the count. The countdown resumes from the held value once halt is cleared.
- R6: Writing any value to the reload register (address 2) refills the counter from the timeout and cancels a pending second stage. A later run of T ticks therefore gives only a first-stage expiry.
- R7: A second consecutive expiry with no reload in between sets the second-timeout flag (status bit 1). If the no-reboot bit is off, it also drives `rst_req` high for exactly one cycle, the cycle after the expiring tick.
- R8: The boot-status flag (status bit 2) sets on the clock edge that ends the `rst_req` pulse.
- R9: Control bit 1 reads as the OR of the software no-reboot bit and the `noreboot_strap` input. While it reads 1, a second expiry still sets status bit 1 but issues no `rst_req`.
- R10: Writing a 1 to a status bit clears that flag. Writing a 0 leaves it unchanged. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data valid the next cycle |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| tick | input | 1 | Count enable pulse |
| noreboot_strap | input | 1 | Strap that forces the no-reboot bit |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A counter that is off by one shows up as the status read after the (T-1)-th or T-th tick disagreeing with the expected flag, so the error is seen within one timeout period. A pending-second-stage bit that is wrong either survives a reload or is lost. That error surfaces one period later, as an unexpected `rst_req` pulse or a missing one, together with a wrong status bit 1. A corrupted halt or range decision appears at the very next timer read-back, or as a flag appearing while halted.

// File: rtl/wdt_pkg.sv
// Shared definitions for the two-stage watchdog: register addresses,
// status flag positions and the per-variant field geometry.
package wdt_pkg;

    localparam int ADDR_W = 2;
    localparam int NFLG   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_TIMER  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_STATUS = 2'd3
    } wdt_reg_e;

    localparam int FLG_FIRST  = 0;
    localparam int FLG_SECOND = 1;
    localparam int FLG_BOOT   = 2;

    // Width of the timeout field for the chosen variant.
    function automatic int tw_f(input bit legacy);
        return legacy ? 6 : 10;
    endfunction

    // Smallest timeout accepted while running.
    function automatic int min_f(input bit legacy);
        return legacy ? 4 : 2;
    endfunction

    // Largest timeout accepted while running.
    function automatic int max_f(input bit legacy);
        return legacy ? 39 : 613;
    endfunction

endpackage

// File: rtl/wdt_status.sv
// Sticky status flags. Each flag is set by its event and cleared by a
// write-one strobe. Assumes the set and clear vectors are single-cycle
// strobes; a set wins over a clear in the same cycle.
module wdt_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flg_q;

        // Hold one flag: set has priority, write-one clears.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flg_q <= 1'b0;
            else if (set_i[g])
                flg_q <= 1'b1;
            else if (clr_i[g])
                flg_q <= 1'b0;
        end

        assign flags_o[g] = flg_q;
    end

endmodule

// File: rtl/wdt_counter.sv
// Countdown core with the two-stage expiry. The counter decrements on
// each tick while not halted. At a count of one or below, a tick is an
// expiry: the first one arms the second stage, the second one requests a
// reset unless no-reboot is in effect. A reload refills the count and
// disarms the second stage. Assumes tick is a one-cycle enable.
module wdt_counter #(
    parameter int TW     = 10,
    parameter int DEF_TO = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          halt,
    input  logic          reload,
    input  logic          nr_eff,
    input  logic [TW-1:0] timeout,
    output logic [TW-1:0] cnt,
    output logic          exp_first,
    output logic          exp_second,
    output logic          rst_req
);

    logic armed2_q;
    logic rst_q;
    logic run_tick;
    logic at_end;

    assign run_tick   = tick && !halt && !reload;
    assign at_end     = (cnt <= TW'(1));
    assign exp_first  = run_tick && at_end && !armed2_q;
    assign exp_second = run_tick && at_end && armed2_q;
    assign rst_req    = rst_q;

    // Advance the count, track the armed second stage, and register the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= TW'(DEF_TO);
            armed2_q <= 1'b0;
            rst_q    <= 1'b0;
        end else begin
            rst_q <= exp_second && !nr_eff;
            if (reload) begin
                cnt      <= timeout;
                armed2_q <= 1'b0;
            end else if (run_tick) begin
                if (at_end) begin
                    cnt      <= timeout;
                    armed2_q <= !armed2_q;
                end else begin
                    cnt <= cnt - TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/wdt_regs.sv
// Register file of the watchdog: control (halt, no-reboot), timer
// (timeout field with a range check while running), reload strobe and
// the status write-one-clear strobes. Read data is registered on rd_en.
// Assumes one access per cycle and a bus at least 16 bits wide.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int DATA_W = 16,
    parameter int DEF_TO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              strap,
    input  logic [NFLG-1:0]   flags,
    output logic              halt,
    output logic              nr_eff,
    output logic [tw_f(LEGACY)-1:0] timeout,
    output logic              reload,
    output logic              wr_timer,
    output logic [NFLG-1:0]   clr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int TW   = tw_f(LEGACY);
    localparam int TMIN = min_f(LEGACY);
    localparam int TMAX = max_f(LEGACY);

    logic          nr_q;
    logic          wr_ctrl;
    logic [TW-1:0] field;
    logic          in_range;
    logic [DATA_W-1:0] rd_mux;
    logic          unused_bits;

    assign wr_ctrl  = wr_en && (addr == REG_CTRL);
    assign wr_timer = wr_en && (addr == REG_TIMER);
    assign reload   = wr_en && (addr == REG_RELOAD);
    assign clr      = (wr_en && (addr == REG_STATUS)) ? wr_data[NFLG-1:0] : '0;
    assign field    = wr_data[TW-1:0];
    assign in_range = (field >= TW'(TMIN)) && (field <= TW'(TMAX));
    assign nr_eff   = nr_q || strap;
    assign unused_bits = ^wr_data;

    // Control bits: halt starts set, software no-reboot starts clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt <= 1'b1;
            nr_q <= 1'b0;
        end else if (wr_ctrl) begin
            halt <= wr_data[0];
            nr_q <= wr_data[1];
        end
    end

    // Timeout field: any value while halted, only in-range values while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            timeout <= TW'(DEF_TO);
        else if (wr_timer && (halt || in_range))
            timeout <= field;
    end

    // Select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (addr)
            REG_CTRL:   begin rd_mux[0] = halt; rd_mux[1] = nr_eff; end
            REG_TIMER:  rd_mux[TW-1:0] = timeout;
            REG_STATUS: rd_mux[NFLG-1:0] = flags;
            default:    rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

endmodule

// File: rtl/wdog_two_stage.sv
// Top of the two-stage watchdog. Connects the register file, the
// countdown core and the sticky status flags. The boot flag is set by the
// reset request itself, so it rises on the edge that ends the pulse.
module wdog_two_stage
    import wdt_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int DEF_TO = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        tick,
    input  logic        noreboot_strap,
    output logic        rst_req
);

    localparam int TW = tw_f(LEGACY);

    logic            halt_w;
    logic            nr_eff_w;
    logic            reload_w;
    logic            wr_timer_w;
    logic [TW-1:0]   timeout_w;
    logic [TW-1:0]   cnt_w;
    logic            exp_first_w;
    logic            exp_second_w;
    logic [NFLG-1:0] clr_w;
    logic [NFLG-1:0] set_w;
    logic [NFLG-1:0] flags_w;

    wdt_regs #(
        .LEGACY (LEGACY),
        .DATA_W (16),
        .DEF_TO (DEF_TO)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .strap    (noreboot_strap),
        .flags    (flags_w),
        .halt     (halt_w),
        .nr_eff   (nr_eff_w),
        .timeout  (timeout_w),
        .reload   (reload_w),
        .wr_timer (wr_timer_w),
        .clr      (clr_w),
        .rd_data  (rd_data)
    );

    wdt_counter #(
        .TW     (TW),
        .DEF_TO (DEF_TO)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .halt       (halt_w),
        .reload     (reload_w),
        .nr_eff     (nr_eff_w),
        .timeout    (timeout_w),
        .cnt        (cnt_w),
        .exp_first  (exp_first_w),
        .exp_second (exp_second_w),
        .rst_req    (rst_req)
    );

    assign set_w[FLG_FIRST]  = exp_first_w;
    assign set_w[FLG_SECOND] = exp_second_w;
    assign set_w[FLG_BOOT]   = rst_req;

    wdt_status #(
        .N (NFLG)
    ) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_w),
        .clr_i   (clr_w),
        .flags_o (flags_w)
    );

endmodule

// File: rtl/wdt_chk.sv
// Assertion checker for the two-stage watchdog, bound into the top.
// Observes the reset request, the flags, the count and the register
// write decode; drives nothing.
module wdt_chk
    import wdt_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rst_req,
    input logic                    halt,
    input logic                    reload,
    input logic                    nr_eff,
    input logic                    wr_timer,
    input logic [tw_f(LEGACY)-1:0] wr_field,
    input logic [tw_f(LEGACY)-1:0] timeout,
    input logic [tw_f(LEGACY)-1:0] cnt,
    input logic [NFLG-1:0]         flags
);

    localparam int TW   = tw_f(LEGACY);
    localparam int TMIN = min_f(LEGACY);
    localparam int TMAX = max_f(LEGACY);

    logic bad_field;
    assign bad_field = (wr_field < TW'(TMIN)) || (wr_field > TW'(TMAX));

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7

    AST_RST_WITH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flags[FLG_SECOND]); // R7

    AST_BOOT_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> flags[FLG_BOOT]); // R8

    AST_NOREBOOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(nr_eff)); // R9

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(cnt)); // R5

    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_timer && !halt && bad_field) |=> $stable(timeout)); // R3

    AST_RELOAD_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == $past(timeout))); // R6

endmodule

bind wdog_two_stage wdt_chk #(
    .LEGACY (LEGACY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .halt     (halt_w),
    .reload   (reload_w),
    .nr_eff   (nr_eff_w),
    .wr_timer (wr_timer_w),
    .wr_field (wr_data[TW-1:0]),
    .timeout  (timeout_w),
    .cnt      (cnt_w),
    .flags    (flags_w)
);

// File: tb/sim_wdog_two_stage.sv
// Bench for the two-stage watchdog: u0 is the wide variant, u1 the
// legacy variant. A vector table covers register behaviour; directed
// tests cover reset, countdown, both expiry stages, halt and no-reboot.
module sim_wdog_two_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, wr1 = 1'b0, rd0 = 1'b0, rd1 = 1'b0;
    logic        tick0 = 1'b0, tick1 = 1'b0;
    logic        strap0 = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdat0, rdat1;
    logic        rreq0, rreq1;
    int          rcnt0 = 0, rcnt1 = 0;
    int          total = 0, bad = 0;

    localparam logic [1:0] A_C = 2'd0, A_T = 2'd1, A_L = 2'd2, A_S = 2'd3;

    always #4 clk = ~clk;

    wdog_two_stage #(.LEGACY(1'b0), .DEF_TO(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr0), .rd_en(rd0), .addr(addr),
        .wr_data(wdata), .rd_data(rdat0), .tick(tick0),
        .noreboot_strap(strap0), .rst_req(rreq0));

    wdog_two_stage #(.LEGACY(1'b1), .DEF_TO(4)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr1), .rd_en(rd1), .addr(addr),
        .wr_data(wdata), .rd_data(rdat1), .tick(tick1),
        .noreboot_strap(1'b0), .rst_req(rreq1));

    // Count reset-request cycles of each instance.
    always @(posedge clk) begin
        if (rreq0) rcnt0 <= rcnt0 + 1;
        if (rreq1) rcnt1 <= rcnt1 + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit s, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (s) wr1 = 1'b1; else wr0 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        addr = a;
        if (s) rd1 = 1'b1; else rd0 = 1'b1;
        @(negedge clk);
        rd0 = 1'b0; rd1 = 1'b0;
        chk(req, s ? int'(rdat1) : int'(rdat0), exp);
    endtask

    task automatic ticks(input bit s, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (s) tick1 = 1'b1; else tick0 = 1'b1;
            @(negedge clk);
            tick0 = 1'b0; tick1 = 1'b0;
        end
    endtask

    // {sel, read, addr, data-or-expected, requirement}
    localparam int NV = 27;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd1, 16'hFC64, 4'd2},  // R2 upper bits ignored
        {1'b0, 1'b1, 2'd1, 16'h0064, 4'd2},
        {1'b0, 1'b0, 2'd1, 16'h0001, 4'd3},  // R3 halted accepts 1
        {1'b0, 1'b1, 2'd1, 16'h0001, 4'd3},
        {1'b0, 1'b0, 2'd0, 16'h0000, 4'd3},  // run
        {1'b0, 1'b1, 2'd0, 16'h0000, 4'd3},
        {1'b0, 1'b0, 2'd1, 16'h02BC, 4'd3},  // 700 rejected
        {1'b0, 1'b1, 2'd1, 16'h0001, 4'd3},
        {1'b0, 1'b0, 2'd1, 16'h0265, 4'd3},  // 613 accepted
        {1'b0, 1'b1, 2'd1, 16'h0265, 4'd3},
        {1'b0, 1'b0, 2'd1, 16'h0266, 4'd3},  // 614 rejected
        {1'b0, 1'b1, 2'd1, 16'h0265, 4'd3},
        {1'b0, 1'b0, 2'd1, 16'h0001, 4'd3},  // 1 rejected
        {1'b0, 1'b1, 2'd1, 16'h0265, 4'd3},
        {1'b0, 1'b0, 2'd1, 16'h0002, 4'd3},  // 2 accepted
        {1'b0, 1'b1, 2'd1, 16'h0002, 4'd3},
        {1'b1, 1'b0, 2'd1, 16'h01E5, 4'd2},  // R2 legacy field 6 bits
        {1'b1, 1'b1, 2'd1, 16'h0025, 4'd2},
        {1'b1, 1'b0, 2'd0, 16'h0000, 4'd3},  // legacy run
        {1'b1, 1'b0, 2'd1, 16'h0028, 4'd3},  // 40 rejected
        {1'b1, 1'b1, 2'd1, 16'h0025, 4'd3},
        {1'b1, 1'b0, 2'd1, 16'h0003, 4'd3},  // 3 rejected
        {1'b1, 1'b1, 2'd1, 16'h0025, 4'd3},
        {1'b1, 1'b0, 2'd1, 16'h0027, 4'd3},  // 39 accepted
        {1'b1, 1'b1, 2'd1, 16'h0027, 4'd3},
        {1'b1, 1'b0, 2'd1, 16'h0004, 4'd3},  // 4 accepted
        {1'b1, 1'b1, 2'd1, 16'h0004, 4'd3}
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state on both variants
        for (int s = 0; s < 2; s++) begin
            rd(s[0], A_C, 1, "R1");
            rd(s[0], A_T, 4, "R1");
            rd(s[0], A_S, 0, "R1");
        end
        chk("R1", int'(rreq0), 0);
        chk("R1", int'(rreq1), 0);

        // Register vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22])
                rd(VEC[i][23], VEC[i][21:20], int'(VEC[i][19:4]),
                   $sformatf("R%0d", VEC[i][3:0]));
            else
                wr(VEC[i][23], VEC[i][21:20], VEC[i][19:4]);
        end

        // R4 first expiry on the T-th tick
        wr(0, A_T, 16'd5);
        wr(0, A_L, 16'd0);
        ticks(0, 4);
        rd(0, A_S, 0, "R4");
        ticks(0, 1);
        rd(0, A_S, 1, "R4");
        chk("R4", rcnt0, 0);

        // R6 reload cancels the pending second stage
        ticks(0, 4);
        wr(0, A_L, 16'hA5A5);
        ticks(0, 5);
        rd(0, A_S, 1, "R6");
        chk("R6", rcnt0, 0);

        // R10 write-one clears
        wr(0, A_S, 16'h0001);
        rd(0, A_S, 0, "R10");

        // R7 second expiry: flag and a single-cycle request; R8 boot flag
        ticks(0, 4);
        rd(0, A_S, 0, "R7");
        chk("R7", rcnt0, 0);
        ticks(0, 1);
        rd(0, A_S, 6, "R7");
        chk("R7", rcnt0, 1);
        chk("R8", int'(rdat0[2]), 1);
        wr(0, A_S, 16'h0002);
        rd(0, A_S, 4, "R10");
        wr(0, A_S, 16'h0004);
        rd(0, A_S, 0, "R10");

        // R5 halt freezes the count, resume continues it
        wr(0, A_C, 16'h0001);
        ticks(0, 20);
        rd(0, A_S, 0, "R5");
        wr(0, A_C, 16'h0000);
        ticks(0, 4);
        rd(0, A_S, 0, "R5");
        ticks(0, 1);
        rd(0, A_S, 1, "R5");

        // R9 software no-reboot bit
        wr(0, A_C, 16'h0002);
        rd(0, A_C, 2, "R9");
        wr(0, A_L, 16'd0);
        wr(0, A_S, 16'h0007);
        ticks(0, 10);
        rd(0, A_S, 3, "R9");
        chk("R9", rcnt0, 1);

        // R9 strap forces no-reboot
        wr(0, A_C, 16'h0000);
        strap0 = 1'b1;
        rd(0, A_C, 2, "R9");
        wr(0, A_L, 16'd0);
        wr(0, A_S, 16'h0007);
        ticks(0, 10);
        rd(0, A_S, 3, "R9");
        chk("R9", rcnt0, 1);
        strap0 = 1'b0;
        rd(0, A_C, 0, "R9");

        // R7 legacy variant two-stage expiry with timeout 4
        wr(1, A_L, 16'd0);
        ticks(1, 8);
        rd(1, A_S, 7, "R7");
        chk("R7", rcnt1, 1);

        summary();
        $finish;
    end

endmodule